// File: doc/BRIEF.md
# Sector Write-Guard with Lockdown

This block keeps the write-permission state of a flash array that is split into 128 sectors of 64 KB each. Every sector carries a protection flag and a lockdown flag. A command decoder in front of it presents one decoded command per cycle: protect or unprotect one sector, protect or unprotect every sector at once, write the register-lock flag, write the lockdown-enable flag, lock down one sector, or freeze the lockdown feature. Alongside each command the decoder supplies the write-protect pin level, the write-enable latch level and whether a program or erase is currently suspended.

The array engine asks the block, through a request address, whether a program or erase there may go ahead. The block answers combinationally from its state. It also reports the register-lock flag, a two-bit summary of how many sectors are protected, and a one-cycle request to clear the write-enable latch whenever a write-enabled command has been consumed. The lockdown-enable and freeze flags are internal; their effect is visible only in whether lockdown commands take hold.

Top module: `sector_guard`

## Requirements
- R1: After a cycle with `rst_n` low at a clock edge, every sector is protected, no sector is locked down, `sprl` is 0 and `swp` is 2'b11.
- R2: The sector index is `cmd_addr[22:16]` for commands and `req_addr[22:16]` for requests; other address bits have no effect. `req_allow` is 1 exactly when the requested sector is neither protected nor locked down.
- R3: With `wel_in`=1, op 1 sets and op 2 clears the protection flag of the addressed sector from the next cycle on. Other sectors are not changed.
- R4: With `wel_in`=1 and no suspension, op 3 sets and op 4 clears the protection flag of every sector.
- R5: Op 5 copies `cmd_arg` into `sprl` only when `wp_n` is 1. While `sprl` is 1 and `wp_n` is 0, ops 1 to 4 change no protection flag.
- R6: Op 7, with `wel_in`=1, the lockdown-enable flag set (op 6 with `cmd_arg`=1) and no freeze, locks down the addressed sector. A locked-down sector is denied from then on, whatever its protection flag. Its lockdown cannot be cleared by any command.
- R7: Op 8, with `wel_in`=1 and lockdown enabled, freezes lockdown. After that, op 7 locks no further sector.
- R8: Op 3 or 4 presented while `susp_any` is 1 changes no sector, but `wel_clr` is still 1 in that cycle.
- R9: A command presented with `wel_in`=0 changes no state and leaves `wel_clr` at 0.
- R10: `swp` is 2'b00 when no sector is protected, 2'b11 when all are protected, and 2'b01 otherwise.
- R11: `wel_clr` is 1, in the same cycle, for any command with op 1 to 8 and `wel_in`=1. It is 0 for op 0 and for ops 9 to 15.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | A decoded command is present this cycle |
| cmd_op | input | 4 | Command code (0 none, 1 to 8 as in the requirements) |
| cmd_arg | input | 1 | Value written by ops 5 and 6 |
| cmd_addr | input | 24 | Address selecting the sector for ops 1, 2 and 7 |
| wp_n | input | 1 | Write-protect pin, 0 = asserted |
| wel_in | input | 1 | Current write-enable latch value |
| susp_any | input | 1 | A program or erase is suspended |
| req_addr | input | 24 | Address of a program or erase request |
| req_allow | output | 1 | Request may proceed |
| sprl | output | 1 | Register-lock flag |
| swp | output | 2 | Protection summary |
| wel_clr | output | 1 | Clear the write-enable latch |

## Verification
Single-sector changes are tried on the first, last and a middle sector, with bit 23 set in the address. This separates correct index decoding from aliasing and from off-by-one decoding. Global operations are applied with and without suspension, and under every combination of register lock and pin level. This tells a correct joint gate from one that tests only the pin or only the lock. Lockdown is tried before enable, after enable, and after freeze, and is followed by unprotect and global unprotect, so that a lockdown which only sets the protection flag is caught. A long random phase mixes all codes, including undefined ones and commands with the latch clear, against a behavioural model compared every cycle.

// File: rtl/sg_pkg.sv
// Shared command codes for the sector write-guard.
// Assumes a 4-bit command code delivered by an upstream decoder.
package sg_pkg;
    typedef enum logic [3:0] {
        SG_NOP        = 4'd0,
        SG_PROT_ONE   = 4'd1,
        SG_UNPROT_ONE = 4'd2,
        SG_PROT_ALL   = 4'd3,
        SG_UNPROT_ALL = 4'd4,
        SG_WR_LOCKREG = 4'd5,
        SG_WR_LDEN    = 4'd6,
        SG_LOCKDOWN   = 4'd7,
        SG_FREEZE     = 4'd8
    } sg_op_e;
endpackage

// File: rtl/sg_cmd_gate.sv
// Command gate: turns one decoded command plus the pin, latch and
// suspension levels into single-purpose update strobes.
// Assumes the register-lock, lockdown-enable and freeze flags come
// from registers in the parent.
module sg_cmd_gate
    import sg_pkg::*;
(
    input  logic       cmd_valid,
    input  logic [3:0] cmd_op,
    input  logic       wp_n,
    input  logic       wel_in,
    input  logic       susp_any,
    input  logic       sprl_q,
    input  logic       lden_q,
    input  logic       frz_q,
    output logic       set_one,
    output logic       clr_one,
    output logic       set_all,
    output logic       clr_all,
    output logic       lock_one,
    output logic       lockreg_we,
    output logic       lden_we,
    output logic       frz_set,
    output logic       wel_clr
);
    sg_op_e op;
    logic   live;
    logic   prot_ok;

    // Decode the command code and the shared qualifiers.
    always_comb begin
        op      = sg_op_e'(cmd_op);
        live    = cmd_valid && wel_in;
        prot_ok = !(sprl_q && !wp_n);
    end

    // Produce one strobe per kind of state change.
    always_comb begin
        set_one    = live && prot_ok && (op == SG_PROT_ONE);
        clr_one    = live && prot_ok && (op == SG_UNPROT_ONE);
        set_all    = live && prot_ok && !susp_any && (op == SG_PROT_ALL);
        clr_all    = live && prot_ok && !susp_any && (op == SG_UNPROT_ALL);
        lockreg_we = live && wp_n && (op == SG_WR_LOCKREG);
        lden_we    = live && (op == SG_WR_LDEN);
        lock_one   = live && lden_q && !frz_q && (op == SG_LOCKDOWN);
        frz_set    = live && lden_q && (op == SG_FREEZE);
        wel_clr    = live && (cmd_op != 4'd0) && (cmd_op <= 4'd8);
    end
endmodule

// File: rtl/sg_sector_bits.sv
// Per-sector protection and lockdown flags.
// Assumes at most one sector is selected per cycle; global strobes
// win over single-sector strobes. Lockdown flags only ever set.
module sg_sector_bits #(
    parameter int NUM_SECT = 128,
    localparam int SW = $clog2(NUM_SECT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [SW-1:0]       sel,
    input  logic                set_one,
    input  logic                clr_one,
    input  logic                set_all,
    input  logic                clr_all,
    input  logic                lock_one,
    output logic [NUM_SECT-1:0] prot_vec,
    output logic [NUM_SECT-1:0] lock_vec
);
    for (genvar i = 0; i < NUM_SECT; i++) begin : g_sec
        logic hit;
        assign hit = (sel == SW'(i));

        // Protection flag of sector i.
        always_ff @(posedge clk) begin
            if (!rst_n)                prot_vec[i] <= 1'b1;
            else if (set_all)          prot_vec[i] <= 1'b1;
            else if (clr_all)          prot_vec[i] <= 1'b0;
            else if (hit && set_one)   prot_vec[i] <= 1'b1;
            else if (hit && clr_one)   prot_vec[i] <= 1'b0;
        end

        // Lockdown flag of sector i, set-once.
        always_ff @(posedge clk) begin
            if (!rst_n)                lock_vec[i] <= 1'b0;
            else if (hit && lock_one)  lock_vec[i] <= 1'b1;
        end

        assert_lock_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
            lock_vec[i] |=> lock_vec[i]);
    end
endmodule

// File: rtl/sg_summary.sv
// Summarises the protection flags into a two-bit code:
// 00 none, 01 some, 11 all.
module sg_summary #(
    parameter int NUM_SECT = 128
) (
    input  logic [NUM_SECT-1:0] prot_vec,
    output logic [1:0]          swp
);
    // Reduce the flag vector to the summary code.
    always_comb begin
        swp = {&prot_vec, |prot_vec};
    end
endmodule

// File: rtl/sector_guard.sv
// Sector write-guard top: holds the register-lock, lockdown-enable and
// freeze flags, instantiates the gate, the per-sector flags and the
// summary, and answers program/erase requests combinationally.
// Assumes one decoded command per cycle and synchronous active-low reset.
module sector_guard #(
    parameter int NUM_SECT = 128,
    parameter int ADDR_W   = 24,
    parameter int SECT_LSB = 16,
    localparam int SW = $clog2(NUM_SECT)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [3:0]        cmd_op,
    input  logic              cmd_arg,
    input  logic [ADDR_W-1:0] cmd_addr,
    input  logic              wp_n,
    input  logic              wel_in,
    input  logic              susp_any,
    input  logic [ADDR_W-1:0] req_addr,
    output logic              req_allow,
    output logic              sprl,
    output logic [1:0]        swp,
    output logic              wel_clr
);
    logic                sprl_q, lden_q, frz_q;
    logic                set_one, clr_one, set_all, clr_all, lock_one;
    logic                lockreg_we, lden_we, frz_set;
    logic [NUM_SECT-1:0] prot_vec, lock_vec;
    logic [SW-1:0]       cmd_sec, req_sec;

    assign cmd_sec = cmd_addr[SECT_LSB +: SW];
    assign req_sec = req_addr[SECT_LSB +: SW];

    sg_cmd_gate u_gate (
        .cmd_valid (cmd_valid),
        .cmd_op    (cmd_op),
        .wp_n      (wp_n),
        .wel_in    (wel_in),
        .susp_any  (susp_any),
        .sprl_q    (sprl_q),
        .lden_q    (lden_q),
        .frz_q     (frz_q),
        .set_one   (set_one),
        .clr_one   (clr_one),
        .set_all   (set_all),
        .clr_all   (clr_all),
        .lock_one  (lock_one),
        .lockreg_we(lockreg_we),
        .lden_we   (lden_we),
        .frz_set   (frz_set),
        .wel_clr   (wel_clr)
    );

    sg_sector_bits #(.NUM_SECT(NUM_SECT)) u_bits (
        .clk     (clk),
        .rst_n   (rst_n),
        .sel     (cmd_sec),
        .set_one (set_one),
        .clr_one (clr_one),
        .set_all (set_all),
        .clr_all (clr_all),
        .lock_one(lock_one),
        .prot_vec(prot_vec),
        .lock_vec(lock_vec)
    );

    sg_summary #(.NUM_SECT(NUM_SECT)) u_sum (
        .prot_vec(prot_vec),
        .swp     (swp)
    );

    // Register-lock flag, written only with the pin released.
    always_ff @(posedge clk) begin
        if (!rst_n)          sprl_q <= 1'b0;
        else if (lockreg_we) sprl_q <= cmd_arg;
    end

    // Lockdown-enable flag.
    always_ff @(posedge clk) begin
        if (!rst_n)       lden_q <= 1'b0;
        else if (lden_we) lden_q <= cmd_arg;
    end

    // Freeze flag, set-once.
    always_ff @(posedge clk) begin
        if (!rst_n)       frz_q <= 1'b0;
        else if (frz_set) frz_q <= 1'b1;
    end

    // Request answer from the flags of the requested sector.
    always_comb begin
        req_allow = !prot_vec[req_sec] && !lock_vec[req_sec];
        sprl      = sprl_q;
    end

    assert_deny_locked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        lock_vec[req_sec] |-> !req_allow);
    assert_lockreg_pin_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !wp_n |=> $stable(sprl_q));
    assert_freeze_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        frz_q |=> frz_q);
    assert_suspend_abort_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && wel_in && susp_any && (cmd_op == 4'd3 || cmd_op == 4'd4))
        |=> $stable(prot_vec));
    assert_no_latch_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !wel_in) |=> ($stable(prot_vec) && $stable(lock_vec) && $stable(sprl_q)));
    assert_no_clr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !wel_in |-> !wel_clr);
endmodule

// File: tb/sector_guard_test.sv
`timescale 1ns/1ps
module sector_guard_test;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        cmd_valid;
    logic [3:0]  cmd_op;
    logic        cmd_arg;
    logic [23:0] cmd_addr;
    logic        wp_n;
    logic        wel_in;
    logic        susp_any;
    logic [23:0] req_addr;
    logic        req_allow;
    logic        sprl;
    logic [1:0]  swp;
    logic        wel_clr;

    bit  mprot [128];
    bit  mlock [128];
    bit  msprl, mlden, mfrz;
    int  nchk = 0;
    int  nfail = 0;
    bit  done = 0;

    always #2 clk = ~clk;

    sector_guard uut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
        .cmd_arg(cmd_arg), .cmd_addr(cmd_addr), .wp_n(wp_n), .wel_in(wel_in),
        .susp_any(susp_any), .req_addr(req_addr), .req_allow(req_allow),
        .sprl(sprl), .swp(swp), .wel_clr(wel_clr)
    );

    task automatic chk(input string tag, input string what, input int act, input int exp);
        nchk++;
        if (act != exp) begin
            nfail++;
            $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
        end
    endtask

    function automatic int model_swp();
        int n = 0;
        for (int i = 0; i < 128; i++) n += mprot[i];
        if (n == 0) return 0;
        if (n == 128) return 3;
        return 1;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 128; i++) begin
            mprot[i] = 1'b1;
            mlock[i] = 1'b0;
        end
        msprl = 0; mlden = 0; mfrz = 0;
    endtask

    // One cycle: drive, compare all outputs, then advance the model.
    task automatic step(input string tag, input int op, input bit arg, input int sec,
                        input bit w, input bit wp, input bit su, input int rsec);
        bit pok;
        @(negedge clk);
        cmd_valid = (op != 0);
        cmd_op    = op[3:0];
        cmd_arg   = arg;
        cmd_addr  = {1'b1, sec[6:0], 16'h5a3c};
        wel_in    = w;
        wp_n      = wp;
        susp_any  = su;
        req_addr  = {1'b1, rsec[6:0], 16'hc3a5};
        #1;
        chk(tag, "wel_clr", int'(wel_clr), int'(w && op >= 1 && op <= 8));
        chk(tag, "req_allow", int'(req_allow), int'(!mprot[rsec] && !mlock[rsec]));
        chk(tag, "sprl", int'(sprl), int'(msprl));
        chk(tag, "swp", int'(swp), model_swp());
        pok = !(msprl && !wp);
        @(posedge clk);
        if (w && op != 0) begin
            case (op)
                1: if (pok) mprot[sec] = 1;
                2: if (pok) mprot[sec] = 0;
                3: if (pok && !su) for (int i = 0; i < 128; i++) mprot[i] = 1;
                4: if (pok && !su) for (int i = 0; i < 128; i++) mprot[i] = 0;
                5: if (wp) msprl = arg;
                6: mlden = arg;
                7: if (mlden && !mfrz) mlock[sec] = 1;
                8: if (mlden) mfrz = 1;
                default: ;
            endcase
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", nchk, nfail);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 4);
        nchk++;
        nfail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        rst_n = 0; cmd_valid = 0; cmd_op = 0; cmd_arg = 0; cmd_addr = 0;
        wp_n = 1; wel_in = 0; susp_any = 0; req_addr = 0;
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;

        // R1 reset state
        step("R1", 0, 0, 0, 0, 1, 0, 5);
        step("R1", 0, 0, 0, 0, 1, 0, 127);
        // R9 unprotect without the latch
        step("R9", 2, 0, 5, 0, 1, 0, 5);
        step("R9", 0, 0, 0, 0, 1, 0, 5);
        // R3 single-sector changes, edge sectors; R2 decoding
        step("R3", 2, 0, 5, 1, 1, 0, 5);
        step("R2", 0, 0, 0, 0, 1, 0, 5);
        step("R2", 0, 0, 0, 0, 1, 0, 6);
        step("R3", 2, 0, 127, 1, 1, 0, 4);
        step("R3", 2, 0, 0, 1, 1, 0, 127);
        step("R3", 1, 0, 5, 1, 1, 0, 0);
        step("R10", 0, 0, 0, 0, 1, 0, 5);
        // R4 global operations, R10 summary codes
        step("R4", 4, 0, 0, 1, 1, 0, 9);
        step("R10", 0, 0, 0, 0, 1, 0, 9);
        step("R4", 3, 0, 0, 1, 1, 0, 9);
        step("R10", 0, 0, 0, 0, 1, 0, 9);
        step("R4", 4, 0, 0, 1, 1, 0, 9);
        // R8 global while suspended
        step("R8", 3, 0, 0, 1, 1, 1, 9);
        step("R8", 0, 0, 0, 0, 1, 0, 9);
        // R5 lock flag and pin
        step("R5", 5, 1, 0, 1, 0, 0, 3);
        step("R5", 0, 0, 0, 0, 1, 0, 3);
        step("R5", 5, 1, 0, 1, 1, 0, 3);
        step("R5", 1, 0, 3, 1, 0, 0, 3);
        step("R5", 3, 0, 0, 1, 0, 0, 3);
        step("R5", 1, 0, 3, 1, 1, 0, 3);
        step("R5", 5, 0, 0, 1, 0, 0, 3);
        step("R5", 5, 0, 0, 1, 1, 0, 3);
        step("R5", 0, 0, 0, 0, 1, 0, 3);
        // R6 lockdown
        step("R6", 7, 0, 10, 1, 1, 0, 10);
        step("R6", 6, 1, 0, 1, 1, 0, 10);
        step("R6", 7, 0, 10, 1, 1, 0, 10);
        step("R6", 2, 0, 10, 1, 1, 0, 10);
        step("R6", 4, 0, 0, 1, 1, 0, 10);
        step("R6", 0, 0, 0, 0, 1, 0, 10);
        // R7 freeze
        step("R7", 8, 0, 0, 1, 1, 0, 11);
        step("R7", 7, 0, 11, 1, 1, 0, 11);
        step("R7", 6, 1, 0, 1, 1, 0, 11);
        step("R7", 7, 0, 11, 1, 1, 0, 11);
        step("R7", 0, 0, 0, 0, 1, 0, 11);
        // R11 undefined codes
        step("R11", 9, 0, 0, 1, 1, 0, 11);
        step("R11", 15, 0, 0, 1, 1, 0, 11);
        step("R11", 0, 0, 0, 1, 1, 0, 11);

        // Reset again, then a random mix against the model.
        @(negedge clk);
        rst_n = 0;
        @(posedge clk);
        model_reset();
        @(negedge clk);
        rst_n = 1;
        step("R1", 0, 0, 0, 0, 1, 0, 10);
        for (int k = 0; k < 3000; k++) begin
            int op;
            int sel;
            op  = int'($urandom_range(0, 12));
            sel = int'($urandom_range(0, 3));
            step("R3", op, 1'($urandom), (sel == 0) ? 0 : (sel == 1) ? 127 : int'($urandom_range(0, 7)),
                 ($urandom_range(0, 3) != 0), ($urandom_range(0, 2) != 0),
                 ($urandom_range(0, 4) == 0), int'($urandom_range(0, 7)));
        end
        finish_run();
    end
endmodule